// File: doc/BRIEF.md
# Serial Configuration Bitstream Loader with Chain Forwarding

This block takes a configuration bitstream that arrives one bit per configuration-clock rising edge on a serial data pin. It packs the bits into bytes for the write port of a configuration memory. A length input sets how many bits belong to this device. Once that many bits have been taken, the block stops consuming. Every later bit is passed out on a serial output, so that the next device in a chain (its input wired to this output) can load its own frame from the same stream.

The block runs entirely in the system clock domain. A build parameter selects one of two clock sources. In the master variant, a divider driven by a run enable produces the configuration clock on an output pin. In the slave variant, an externally driven configuration clock is watched for rising edges. Both variants sample the data and assemble bytes in exactly the same way. A read request input exists only because serial loading has no read path, and the block ignores it. A synchronous restart rewinds the block for a new frame.

Top module: `serial_chain_loader`

## Requirements
- R1: A bit is taken only on a rising edge of the configuration clock. Holding the clock high or low for any number of system cycles takes no further bits, and `serIn` is ignored between edges.
- R2: Consumed bits are packed MSB-first: the first bit of each group of eight lands in `byteData[7]`. `byteValid` is high for exactly one system cycle, the cycle after the edge that captured the eighth bit.
- R3: `frameBits` gives the number of bits this device consumes. `frameDone` rises in the cycle after the edge that captured bit number `frameBits`, and stays high until restart. A value of zero forwards the whole stream.
- R4: While bits are being consumed, and after reset or restart, `serOut` is 1.
- R5: Once the frame is complete, each sampled bit appears on `serOut` in the cycle after its edge, and no `byteValid` is raised.
- R6: A high `restart` clears the bit count, `frameDone` and any partial byte, and sets `serOut` to 1, at the next system clock edge.
- R7: `readReq` has no effect on any output.
- R8: Master variant: while `masterRun` is high, `cfgClkOut` stays low for `CLK_DIV` system cycles and then high for `CLK_DIV` system cycles, starting low. Each rising transition samples `serIn`. While `masterRun` is low, `cfgClkOut` is held low.
- R9: Slave variant: a rising transition of `cfgClkIn` between two system clock edges samples `serIn`, and `cfgClkOut` is held at 0.
- R10: After reset, `serOut` is 1, and `byteValid`, `frameDone` and `cfgClkOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous frame restart |
| frameBits | input | CNT_W | Number of bits this device consumes |
| masterRun | input | 1 | Enables the generated configuration clock (master only) |
| cfgClkIn | input | 1 | External configuration clock (slave only) |
| cfgClkOut | output | 1 | Generated configuration clock (master), else 0 |
| serIn | input | 1 | Serial bitstream input |
| readReq | input | 1 | Read request, ignored |
| serOut | output | 1 | Serial output to the next device in the chain |
| byteData | output | BYTE_W | Assembled configuration byte |
| byteValid | output | 1 | One-cycle strobe for a new byte |
| frameDone | output | 1 | High once this device's frame is consumed |

## Verification
The bench builds two instances. The first is the slave variant with a 32-bit length and 8-bit bytes. The bench drives its configuration clock directly, so it can place each rising edge in a chosen cycle, hold the clock high for several cycles, and end a frame at 0, 8, 16 or 32 bits with a 32-bit stream. The second instance is the master variant with `CLK_DIV` set to 2. This short divider brings the clock's exact low and high phase lengths, the eighth rising edge and the first forwarded bit within a few dozen cycles.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;
  // strobes sent from control to datapath
  typedef struct packed {
    logic clear;     // restart: drop partial byte, park serial output high
    logic shiftEn;   // take serIn into the byte shifter
    logic byteDone;  // this shift completes a byte
    logic fwdEn;     // pass serIn on to the chain output
  } loaderStrobes_t;
endpackage

// File: rtl/cfg_loader_clksrc.sv
`timescale 1ns/1ps
module cfg_loader_clksrc #(
  parameter bit MASTER  = 1'b0,
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic masterRun,
  input  logic cfgClkIn,
  output logic cfgClkOut,
  output logic bitTick
);
  generate
    if (MASTER) begin : g_master
      localparam int DIV_W = $clog2(CLK_DIV + 1);
      logic [DIV_W-1:0] divCnt;
      logic clkQ;
      logic phaseEnd;
      logic unusedExtClk;

      assign unusedExtClk = cfgClkIn;
      assign phaseEnd = (divCnt == DIV_W'(CLK_DIV - 1));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divCnt <= '0;
          clkQ   <= 1'b0;
        end else if (!masterRun) begin
          divCnt <= '0;
          clkQ   <= 1'b0;
        end else if (phaseEnd) begin
          divCnt <= '0;
          clkQ   <= ~clkQ;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end

      assign cfgClkOut = clkQ;
      assign bitTick   = masterRun && phaseEnd && !clkQ;
    end else begin : g_slave
      logic extPrev;
      logic unusedRun;

      assign unusedRun = masterRun;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) extPrev <= 1'b0;
        else       extPrev <= cfgClkIn;
      end

      assign cfgClkOut = 1'b0;
      assign bitTick   = cfgClkIn && !extPrev;
    end
  endgenerate
endmodule

// File: rtl/cfg_loader_ctrl.sv
`timescale 1ns/1ps
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             restart,
  input  logic [CNT_W-1:0] frameBits,
  output loaderStrobes_t   strobes,
  output logic             frameDone
);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [CNT_W-1:0] bitCount;
  logic             fwdFlag;
  logic             consume;
  logic             lastOfByte;
  logic             lastOfFrame;

  assign consume     = !fwdFlag && (bitCount < frameBits);
  assign lastOfByte  = (bitCount[IDX_W-1:0] == IDX_W'(BYTE_W - 1));
  assign lastOfFrame = ((bitCount + CNT_W'(1)) == frameBits);

  always_comb begin
    strobes.clear    = restart;
    strobes.shiftEn  = bitTick && consume && !restart;
    strobes.byteDone = bitTick && consume && !restart && lastOfByte;
    strobes.fwdEn    = bitTick && !consume && !restart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      fwdFlag  <= 1'b0;
    end else if (restart) begin
      bitCount <= '0;
      fwdFlag  <= 1'b0;
    end else if (strobes.shiftEn) begin
      bitCount <= bitCount + CNT_W'(1);
      if (lastOfFrame) fwdFlag <= 1'b1;
    end else if (strobes.fwdEn) begin
      fwdFlag <= 1'b1;
    end
  end

  assign frameDone = fwdFlag;
endmodule

// File: rtl/cfg_loader_dpath.sv
`timescale 1ns/1ps
module cfg_loader_dpath
  import cfg_loader_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  loaderStrobes_t    strobes,
  input  logic              serIn,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              serOut
);
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] shiftNext;

  assign shiftNext = {shiftReg[BYTE_W-2:0], serIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      byteData  <= '0;
      byteValid <= 1'b0;
      serOut    <= 1'b1;
    end else begin
      byteValid <= 1'b0;
      if (strobes.clear) begin
        shiftReg <= '0;
        serOut   <= 1'b1;
      end else begin
        if (strobes.shiftEn) shiftReg <= shiftNext;
        if (strobes.byteDone) begin
          byteData  <= shiftNext;
          byteValid <= 1'b1;
        end
        if (strobes.fwdEn) serOut <= serIn;
      end
    end
  end
endmodule

// File: rtl/serial_chain_loader.sv
`timescale 1ns/1ps
module serial_chain_loader
  import cfg_loader_pkg::*;
#(
  parameter bit MASTER  = 1'b0,
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 32,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic [CNT_W-1:0]  frameBits,
  input  logic              masterRun,
  input  logic              cfgClkIn,
  output logic              cfgClkOut,
  input  logic              serIn,
  input  logic              readReq,
  output logic              serOut,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              frameDone
);
  loaderStrobes_t strobes;
  logic bitTick;
  logic unusedReadReq;

  // serial loading has no read path
  assign unusedReadReq = readReq;

  cfg_loader_clksrc #(.MASTER(MASTER), .CLK_DIV(CLK_DIV)) u_clksrc (
    .clk(clk), .rstN(rstN), .masterRun(masterRun), .cfgClkIn(cfgClkIn),
    .cfgClkOut(cfgClkOut), .bitTick(bitTick)
  );

  cfg_loader_ctrl #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .restart(restart),
    .frameBits(frameBits), .strobes(strobes), .frameDone(frameDone)
  );

  cfg_loader_dpath #(.BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .serIn(serIn),
    .byteData(byteData), .byteValid(byteValid), .serOut(serOut)
  );
endmodule

// File: rtl/serial_chain_loader_chk.sv
`timescale 1ns/1ps
module serial_chain_loader_chk #(
  parameter bit MASTER = 1'b0
) (
  input logic clk,
  input logic rstN,
  input logic restart,
  input logic masterRun,
  input logic cfgClkOut,
  input logic serOut,
  input logic byteValid,
  input logic frameDone
);
  logic unusedChkRun;
  assign unusedChkRun = masterRun;

  // R2: byte strobe lasts a single cycle
  p_byte_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R4: chain output parked high until forwarding starts
  p_hold_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |-> serOut);

  // R5: no bytes once forwarding is under way
  p_no_byte_fwd_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !byteValid);

  // R3: frame completion holds until restart
  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !restart) |=> frameDone);

  // R6: restart rewinds the frame
  p_restart_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!frameDone && serOut && !byteValid));

  generate
    if (MASTER) begin : g_mchk
      // R8: generated clock parked low when not running
      p_clk_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
        !masterRun |=> !cfgClkOut);
    end else begin : g_schk
      // R9: slave never drives the clock output
      p_clk_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
        !cfgClkOut);
    end
  endgenerate
endmodule

bind serial_chain_loader serial_chain_loader_chk #(.MASTER(MASTER)) u_chk (
  .clk(clk), .rstN(rstN), .restart(restart), .masterRun(masterRun),
  .cfgClkOut(cfgClkOut), .serOut(serOut), .byteValid(byteValid),
  .frameDone(frameDone)
);

// File: tb/serial_chain_loader_tb.sv
`timescale 1ns/1ps
module serial_chain_loader_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic restart = 1'b0;
  logic [31:0] frameBits = '0;
  logic cfgClkIn = 1'b0;
  logic serIn = 1'b0;
  logic readReq = 1'b0;
  logic cfgClkOut, serOut, byteValid, frameDone;
  logic [7:0] byteData;

  logic [31:0] mFrame = 32'd8;
  logic mRun = 1'b0;
  logic mClkOut, mSerOut, mValid, mDone;
  logic [7:0] mByte;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic obsValid, obsSer;
  logic [7:0] obsByte;

  always #2.5 clk = ~clk;

  serial_chain_loader u_dut (
    .clk(clk), .rstN(rstN), .restart(restart), .frameBits(frameBits),
    .masterRun(1'b0), .cfgClkIn(cfgClkIn), .cfgClkOut(cfgClkOut),
    .serIn(serIn), .readReq(readReq), .serOut(serOut), .byteData(byteData),
    .byteValid(byteValid), .frameDone(frameDone)
  );

  serial_chain_loader #(.MASTER(1'b1), .CLK_DIV(2)) u_mst (
    .clk(clk), .rstN(rstN), .restart(restart), .frameBits(mFrame),
    .masterRun(mRun), .cfgClkIn(1'b0), .cfgClkOut(mClkOut),
    .serIn(serIn), .readReq(1'b0), .serOut(mSerOut), .byteData(mByte),
    .byteValid(mValid), .frameDone(mDone)
  );

  // stream vectors: {frameBits, 32-bit stream sent MSB first}
  localparam logic [63:0] VEC [4] = '{
    {32'd16, 32'hA5C3_0F81},
    {32'd32, 32'h1234_5678},
    {32'd8,  32'hFF00_F0F0},
    {32'd0,  32'h8000_0001}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input int hold);
    @(negedge clk);
    serIn = b;
    cfgClkIn = 1'b1;
    @(posedge clk); #1;
    obsValid = byteValid; obsByte = byteData; obsSer = serOut;
    for (int h = 1; h < hold; h++) begin
      @(negedge clk);
      serIn = ~serIn;  // toggling while the clock stays high must be ignored (R1)
    end
    @(negedge clk);
    cfgClkIn = 1'b0;
  endtask

  task automatic doRestart();
    @(negedge clk); restart = 1'b1;
    @(posedge clk); #1;
    chk(serOut && !frameDone && !byteValid, "R6", {serOut, frameDone, byteValid}, 3'b100);
    @(negedge clk); restart = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    @(posedge clk); #1;
    chk(serOut && !byteValid && !frameDone, "R10", {serOut, byteValid, frameDone}, 3'b100);
    chk(!mClkOut && mSerOut && !mValid && !mDone, "R10", {mClkOut, mSerOut, mValid, mDone}, 4'b0100);
    @(negedge clk); rstN = 1'b1;

    // table walk: R2, R3, R4, R5, R7
    for (int e = 0; e < 4; e++) begin
      logic [31:0] fb, st;
      fb = VEC[e][63:32];
      st = VEC[e][31:0];
      frameBits = fb;
      doRestart();
      readReq = (e == 1);  // R7: read request must change nothing
      for (int i = 0; i < 32; i++) begin
        logic b;
        b = st[31-i];
        sendBit(b, 1);
        if (i < fb) begin
          chk(obsSer == 1'b1, "R4", {31'b0, obsSer}, 1);
          if (i % 8 == 7)
            chk(obsValid && obsByte == st[31-(i-7) -: 8], e == 1 ? "R2/R7" : "R2",
                {obsValid, obsByte}, {1'b1, st[31-(i-7) -: 8]});
          else
            chk(!obsValid, "R2", {31'b0, obsValid}, 0);
          if (i == fb - 1) chk(frameDone, "R3", {31'b0, frameDone}, 1);
          if (i + 2 == fb) chk(!frameDone, "R3", {31'b0, frameDone}, 0);
        end else begin
          chk(obsSer == b && !obsValid, e == 1 ? "R5/R7" : "R5", {obsSer, obsValid}, {b, 1'b0});
        end
      end
      chk(frameDone, "R3", {31'b0, frameDone}, 1);
      readReq = 1'b0;
    end

    // R6: restart in the middle of a frame discards the partial byte
    frameBits = 32'd16;
    doRestart();
    for (int i = 0; i < 5; i++) sendBit(1'b1, 1);
    doRestart();
    for (int i = 0; i < 16; i++) begin
      logic [15:0] w;
      w = 16'h3C5A;
      sendBit(w[15-i], 1);
      if (i == 7)  chk(obsValid && obsByte == 8'h3C, "R6", {obsValid, obsByte}, 9'h13C);
      if (i == 15) chk(obsValid && obsByte == 8'h5A, "R6", {obsValid, obsByte}, 9'h15A);
    end
    chk(frameDone, "R3", {31'b0, frameDone}, 1);

    // R1: long high phases with data toggling take one bit per edge
    frameBits = 32'd8;
    doRestart();
    for (int i = 0; i < 8; i++) begin
      logic [7:0] w;
      w = 8'hB2;
      sendBit(w[7-i], 5);
      if (i == 7) chk(obsValid && obsByte == 8'hB2, "R1", {obsValid, obsByte}, 9'h1B2);
      else        chk(!obsValid, "R1", {31'b0, obsValid}, 0);
    end
    // R9: slave never drives its clock pin
    chk(!cfgClkOut, "R9", {31'b0, cfgClkOut}, 0);

    // R8: master variant with CLK_DIV=2
    serIn = 1'b1;
    @(negedge clk); mRun = 1'b1;
    begin
      int rises;
      logic prevClk;
      rises = 0;
      prevClk = 1'b0;
      for (int k = 1; k <= 40; k++) begin
        @(posedge clk); #1;
        if (k <= 6) chk(mClkOut == ((k >> 1) & 1), "R8", {31'b0, mClkOut}, (k >> 1) & 1);
        if (mClkOut && !prevClk) begin
          rises++;
          if (rises == 8) begin
            chk(mValid && mByte == 8'hFF && mSerOut, "R8", {mValid, mByte, mSerOut}, 10'h3FF);
            serIn = 1'b0;
          end
          if (rises == 9) chk(!mSerOut && mDone && !mValid, "R8", {mSerOut, mDone, mValid}, 3'b010);
        end
        prevClk = mClkOut;
      end
      chk(rises >= 9, "R8", rises, 9);
    end
    @(negedge clk); mRun = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk(!mClkOut, "R8", {31'b0, mClkOut}, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule